// File: doc/BRIEF.md
# Infrared LED Drive Guard

This block decides, cycle by cycle, whether the infrared emitter is lit. The transmit data level from the link controller drives the LED directly while transmission is allowed. A stuck-on guard counts how long the transmit level has been continuously high. Once the count reaches a limit of roughly 16 µs, the LED is forced dark. It stays dark until the transmit input falls and rises again.

Three controls from the configuration logic can hold the LED off at any moment:
- the shutdown state,
- a cleared transmit-enable bit,
- a busy flag raised while a serial control transaction is using the shared data line.

The block also drives the active-low receive output. That output echoes every emitted pulse and passes the optical detector's pulses through. It idles high and is forced high during shutdown. A power-level code is passed to the analog driver unchanged.

All inputs are plain levels; there is no streaming interface and so no back-pressure. The transmit input is resampled by one register. The gating controls act combinationally on the output, so a request to darken the LED takes effect in the same cycle.

Top module: `ir_led_guard`

## Requirements
- R1: After reset, led_on is 0 and rxd_n is 1.
- R2: While shutdown=0, tx_en=1 and xact_busy=0, and the guard has not expired, led_on equals the txd value sampled at the previous rising clock edge.
- R3: When txd stays high continuously, led_on is high for exactly GUARD_CYC clock cycles and then goes low while txd remains high. GUARD_CYC = CLK_KHZ*GUARD_NS/1_000_000, which is 768 cycles (16 µs at 48 MHz) by default.
- R4: After the guard expires, the LED lights again only once txd has been sampled low for at least one cycle and then sampled high again.
- R5: The on-time count restarts whenever txd is sampled low. A stream of short pulses whose total high time exceeds GUARD_CYC therefore never trips the guard.
- R6: While shutdown=1, led_on is 0 in the same cycle, whatever txd is.
- R7: While tx_en=0 or xact_busy=1, led_on is 0 in the same cycle.
- R8: While shutdown=0, rxd_n is 0 exactly when led_on=1 or rx_light=1, and 1 otherwise.
- R9: While shutdown=1, rxd_n is 1 whatever rx_light and txd are.
- R10: pwr_out always equals pwr_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd | input | 1 | Transmit data level, high requests light |
| shutdown | input | 1 | Shutdown state, high darkens LED and parks rxd_n high |
| tx_en | input | 1 | Transmit-enable configuration bit |
| xact_busy | input | 1 | Serial control transaction in progress |
| rx_light | input | 1 | Detector pulse, high while light is received |
| pwr_in | input | PWR_W | Optical power code from configuration |
| led_on | output | 1 | LED enable to the current driver |
| rxd_n | output | 1 | Active-low receive data |
| pwr_out | output | PWR_W | Power code to the current driver |

## Verification
The hardest situation to reach is the boundary of the guard. This means the exact cycle in which a continuous high stops lighting the LED, and the re-arm after a single low cycle. The bench holds txd high for far longer than the limit and counts the lit cycles against GUARD_CYC. It then drops txd for exactly one clock and confirms the LED lights on the next sampled high. A separate test sends a long burst of short pulses with a total high time well beyond the limit, to show the count restarts. Gating is also exercised while txd is already high and the count is partway through.

// File: rtl/ir_led_guard_pkg.sv
package ir_led_guard_pkg;
  function automatic int unsigned guard_cycles(int unsigned clk_khz, int unsigned guard_ns);
    longint unsigned prod;
    prod = longint'(clk_khz) * longint'(guard_ns);
    return int'(prod / 64'd1_000_000);
  endfunction
endpackage

// File: rtl/ir_led_on_timer.sv
module ir_led_on_timer #(
  parameter int unsigned LIMIT = 768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  output logic txd_s,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_s   <= 1'b0;
      run_cnt <= '0;
    end else begin
      txd_s <= txd;
      if (!txd_s)
        run_cnt <= '0;
      else if (run_cnt != LIM)
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign expired = (run_cnt == LIM);
endmodule

// File: rtl/ir_led_gate.sv
module ir_led_gate (
  input  logic txd_s,
  input  logic expired,
  input  logic shutdown,
  input  logic tx_en,
  input  logic xact_busy,
  output logic led_on
);
  logic permit;
  always_comb begin
    permit = !shutdown && tx_en && !xact_busy;
    led_on = permit && txd_s && !expired;
  end
endmodule

// File: rtl/ir_rx_echo.sv
module ir_rx_echo (
  input  logic shutdown,
  input  logic led_on,
  input  logic rx_light,
  output logic rxd_n
);
  always_comb begin
    rxd_n = shutdown ? 1'b1 : !(led_on || rx_light);
  end
endmodule

// File: rtl/ir_led_guard.sv
module ir_led_guard
  import ir_led_guard_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 48000,
  parameter int unsigned GUARD_NS = 16000,
  parameter int unsigned PWR_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txd,
  input  logic             shutdown,
  input  logic             tx_en,
  input  logic             xact_busy,
  input  logic             rx_light,
  input  logic [PWR_W-1:0] pwr_in,
  output logic             led_on,
  output logic             rxd_n,
  output logic [PWR_W-1:0] pwr_out
);
  localparam int unsigned GUARD_CYC = guard_cycles(CLK_KHZ, GUARD_NS);

  logic txd_s;
  logic expired;

  ir_led_on_timer #(.LIMIT(GUARD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .txd_s   (txd_s),
    .expired (expired)
  );

  ir_led_gate u_gate (
    .txd_s     (txd_s),
    .expired   (expired),
    .shutdown  (shutdown),
    .tx_en     (tx_en),
    .xact_busy (xact_busy),
    .led_on    (led_on)
  );

  ir_rx_echo u_echo (
    .shutdown (shutdown),
    .led_on   (led_on),
    .rx_light (rx_light),
    .rxd_n    (rxd_n)
  );

  assign pwr_out = pwr_in;
endmodule

// File: rtl/ir_led_guard_chk.sv
module ir_led_guard_chk
  import ir_led_guard_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 48000,
  parameter int unsigned GUARD_NS = 16000
) (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic shutdown,
  input logic tx_en,
  input logic xact_busy,
  input logic rx_light,
  input logic led_on,
  input logic rxd_n
);
  localparam int unsigned LIM = guard_cycles(CLK_KHZ, GUARD_NS);
  localparam int unsigned CW  = $clog2(LIM + 2);

  logic [CW-1:0] lit_run;
  logic          seen_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit_run   <= '0;
      seen_edge <= 1'b0;
    end else begin
      seen_edge <= 1'b1;
      if (!led_on)
        lit_run <= '0;
      else if (lit_run != CW'(LIM + 1))
        lit_run <= lit_run + 1'b1;
    end
  end

  assert_lit_needs_txd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && led_on) |-> $past(txd));

  assert_max_on_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    led_on |-> (lit_run < CW'(LIM)));

  assert_shutdown_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !led_on);

  assert_gates_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || xact_busy) |-> !led_on);

  assert_echo_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && (led_on || rx_light)) |-> !rxd_n);

  assert_shutdown_rx_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> rxd_n);
endmodule

bind ir_led_guard ir_led_guard_chk #(.CLK_KHZ(CLK_KHZ), .GUARD_NS(GUARD_NS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txd       (txd),
  .shutdown  (shutdown),
  .tx_en     (tx_en),
  .xact_busy (xact_busy),
  .rx_light  (rx_light),
  .led_on    (led_on),
  .rxd_n     (rxd_n)
);

// File: tb/ir_led_guard_tb.sv
module ir_led_guard_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  GUARD_CYC  = (48000 * 16000) / 1000000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txd = 1'b0, shutdown = 1'b0, tx_en = 1'b1, xact_busy = 1'b0, rx_light = 1'b0;
  logic [1:0] pwr_in = 2'b11;
  logic       led_on, rxd_n;
  logic [1:0] pwr_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ir_led_guard u_dut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .shutdown(shutdown), .tx_en(tx_en),
    .xact_busy(xact_busy), .rx_light(rx_light), .pwr_in(pwr_in),
    .led_on(led_on), .rxd_n(rxd_n), .pwr_out(pwr_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 led_on", led_on, 0);
    check("R1 rxd_n", rxd_n, 1);
  endtask

  task automatic test_short_pulses();
    logic prev = 1'b0;
    int   mism = 0;
    for (int i = 0; i < 1500; i++) begin
      tick();
      txd = ((i % 5) < 3);
      #1;
      if (led_on !== prev) mism++;
      prev = txd;
    end
    check("R2 follow mismatches", mism, 0);
    check("R5 no trip after pulse burst", mism, 0);
    tick(); txd = 1'b0; tick(); #1;
    check("R2 idle after burst", led_on, 0);
  endtask

  task automatic test_stuck_high();
    int lit = 0;
    int first_off = -1;
    tick(); txd = 1'b1;
    for (int i = 0; i < GUARD_CYC + 200; i++) begin
      tick(); #1;
      if (led_on) lit++;
      else if (first_off < 0) first_off = i;
    end
    check("R3 lit cycles", lit, GUARD_CYC);
    check("R3 first dark cycle", first_off, GUARD_CYC);
    check("R4 stays dark while high", led_on, 0);
    check("R8 rxd_n idle after trip", rxd_n, 1);
    tick(); txd = 1'b0;
    tick(); #1;
    check("R4 dark while low", led_on, 0);
    txd = 1'b1;
    tick(); #1;
    check("R4 re-armed by fresh rise", led_on, 1);
    check("R8 echo of pulse", rxd_n, 0);
    txd = 1'b0;
    tick(); tick(); #1;
    check("R8 echo released", rxd_n, 1);
  endtask

  task automatic test_gates();
    shutdown = 1'b1; txd = 1'b1; rx_light = 1'b1;
    tick(); tick(); #1;
    check("R6 shutdown dark", led_on, 0);
    check("R9 shutdown rxd high", rxd_n, 1);
    shutdown = 1'b0; rx_light = 1'b0; #1;
    check("R2 lights when gate lifts", led_on, 1);
    xact_busy = 1'b1; #1;
    check("R7 busy dark", led_on, 0);
    check("R8 rxd_n high while dark", rxd_n, 1);
    xact_busy = 1'b0; tx_en = 1'b0; #1;
    check("R7 tx disabled dark", led_on, 0);
    tx_en = 1'b1; #1;
    check("R2 relit", led_on, 1);
    tick(); txd = 1'b0;
    tick(); tick(); #1;
    check("R2 off after low", led_on, 0);
  endtask

  task automatic test_rx_path();
    rx_light = 1'b1; #1;
    check("R8 detector pulse", rxd_n, 0);
    rx_light = 1'b0; #1;
    check("R8 idle high", rxd_n, 1);
    pwr_in = 2'b01; #1;
    check("R10 power code 01", pwr_out, 1);
    pwr_in = 2'b10; #1;
    check("R10 power code 10", pwr_out, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick(); #1;
    test_reset();
    rst_n = 1'b1;
    tick();
    test_short_pulses();
    test_stuck_high();
    test_gates();
    test_rx_path();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule